// File: doc/BRIEF.md
# Serial Clock Freeze Controller

This block lets a host stop or restart each of twelve clock outputs with one serial word. A free-running serial clock samples a single data line. A frame opens with one low start bit and carries twelve enable bits. Bit k of a frame decides whether output k runs or is parked at logic low. The whole word takes effect in one step, at the edge that samples the last bit. Until that edge, the outputs keep their previous setting.

Each of the twelve outputs has its own gate, and that gate runs in the domain of its own input clock. The gate brings the control bit across through a synchronizer and holds it in a latch that is transparent only while the input clock is low. The gate therefore opens or closes only between pulses, so a pulse is never shortened or stretched. The bank C output zero and the feedback output have no control bit. They are routed around this block and are not part of it.

Top module: `ser_freeze_gate`

## Requirements
- R1: While `rst_n` is low, and after it is released, every enable bit is 1 and every `clk_out[k]` follows `clk_in[k]`. Asserting reset again at any time restores this state.
- R2: When the receiver is idle, a rising `ser_clk` edge that samples `ser_data` low is taken as the start bit. The next twelve rising edges sample D0 through D11, in that order.
- R3: Bit Dk drives `clk_out[k]`. Indices 0 to 3 are bank A outputs 0 to 3. Indices 4 to 7 are bank B outputs 0 to 3. Indices 8 to 10 are bank C outputs 1 to 3. Index 11 is the sync output.
- R4: An enable bit of 0 holds its output at logic 0, and a bit of 1 lets the output follow its input. A new setting reaches the output within SYNC_STAGES+1 rising edges of that output's input clock.
- R5: All twelve bits are applied together at the edge that samples D11. Before that edge, a frame in progress leaves every output on its previous setting.
- R6: Each high pulse on an output lasts exactly one high phase of its input clock, including the pulses around a freeze or a release. No runt or stretched pulse appears.
- R7: While idle, `ser_data` held high changes nothing, however long it stays high.
- R8: Zero-valued data bits inside a frame are not taken as a start bit. A start bit may follow D11 on the very next edge, with no idle bit between the frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Free-running serial clock, sampled on its rising edge |
| ser_data | input | 1 | Serial frame input: a low start bit, then D0 through D11 |
| clk_in | input | 12 | Ungated clocks, indexed as in R3 |
| clk_out | output | 12 | Gated clocks, low while frozen |

## Verification
The bench freezes and releases outputs whose input clocks are unrelated to the serial clock and to each other. It times every output high pulse against the high phase of that output's input clock. A gate that switched during a high phase would show up as a shortened or stretched pulse.

The bench also stops the serial clock in the middle of a frame and inspects the outputs. A receiver that passed bits through one at a time would show some outputs already changed.

An all-zero frame is followed by a second frame, and one frame is sent directly after another. A receiver that took a data zero for a start bit, or that needed an idle bit between frames, would then apply the wrong map. Reset is asserted while outputs are frozen, and every output must come back running.

// File: rtl/ser_freeze_gate.sv
`timescale 1ns/1ps
module ser_freeze_gate #(
  parameter int N_OUT       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic [N_OUT-1:0] clk_in,
  output logic [N_OUT-1:0] clk_out
);
  localparam int            CW   = $clog2(N_OUT);
  localparam logic [CW-1:0] LAST = CW'(N_OUT - 1);

  logic             busy;
  logic [CW-1:0]    cnt;
  logic [N_OUT-1:0] shreg;
  logic [N_OUT-1:0] ctrl;

  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      shreg <= '0;
      ctrl  <= '1;
    end else if (!busy) begin
      if (!ser_data) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else begin
      shreg <= {ser_data, shreg[N_OUT-1:1]};
      cnt   <= cnt + 1'b1;
      if (cnt == LAST) begin
        busy <= 1'b0;
        ctrl <= {ser_data, shreg[N_OUT-1:1]};
      end
    end
  end

  p_start_r2: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (!busy && !ser_data) |=> (busy && cnt == '0));
  p_len_r2: assert property (@(posedge ser_clk) disable iff (!rst_n)
    busy |-> (cnt <= LAST));
  p_idle_r7: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (!busy && ser_data) |=> (!busy && $stable(ctrl)));
  p_hold_r5: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (busy && cnt != LAST) |=> $stable(ctrl));
  p_zero_data_r8: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (busy && cnt != LAST) |=> busy);

  for (genvar g = 0; g < N_OUT; g++) begin : gate
    logic [SYNC_STAGES-1:0] sync;
    logic                   en_lat;
    logic                   en_rise;

    always_ff @(posedge clk_in[g] or negedge rst_n) begin
      if (!rst_n) sync <= '1;
      else        sync <= {sync[SYNC_STAGES-2:0], ctrl[g]};
    end

    always_latch begin
      if (!rst_n)          en_lat <= 1'b1;
      else if (!clk_in[g]) en_lat <= sync[SYNC_STAGES-1];
    end

    assign clk_out[g] = clk_in[g] & en_lat;

    always_ff @(posedge clk_in[g] or negedge rst_n) begin
      if (!rst_n) en_rise <= 1'b1;
      else        en_rise <= en_lat;
    end

    p_no_runt_r6: assert property (@(negedge clk_in[g]) disable iff (!rst_n)
      en_lat == en_rise);
  end
endmodule

// File: tb/tb_ser_freeze_gate.sv
`timescale 1ns/1ps
module tb_ser_freeze_gate;
  localparam int N = 12;

  logic         rst_n = 1'b0;
  logic         sclk  = 1'b0;
  logic         sdat  = 1'b1;
  logic         run   = 1'b1;
  logic         armed = 1'b0;
  wire  [N-1:0] cin;
  wire  [N-1:0] cout;
  logic [N-1:0] model = '1;
  int vectors = 0;
  int errors  = 0;

  ser_freeze_gate #(.N_OUT(N), .SYNC_STAGES(2)) dut (
    .rst_n(rst_n), .ser_clk(sclk), .ser_data(sdat), .clk_in(cin), .clk_out(cout));

  always begin
    #5;
    if (run || sclk) sclk = ~sclk;
  end

  for (genvar i = 0; i < N; i++) begin : gen
    logic    c = 1'b0;
    realtime t_rise = 0.0;
    always #(3 + i) c = ~c;
    assign cin[i] = c;
    always @(posedge cout[i]) t_rise = $realtime;
    always @(negedge cout[i]) begin
      if (armed && rst_n) begin
        vectors++;
        if ($realtime - t_rise != real'(3 + i)) begin
          errors++;
          $display("FAIL R6 out%0d pulse width actual %0t expected %0d ns",
                   i, $realtime - t_rise, 3 + i);
        end
      end
    end
  end

  task automatic check_outs(input logic [N-1:0] exp, input string tag);
    logic [N-1:0] bad = '0;
    logic [N-1:0] got_at = '0;
    #0.5;
    for (int s = 0; s < 240; s++) begin
      for (int i = 0; i < N; i++) begin
        if ((exp[i] && cout[i] !== cin[i]) || (!exp[i] && cout[i] !== 1'b0)) begin
          if (!bad[i]) got_at[i] = cout[i];
          bad[i] = 1'b1;
        end
      end
      #1;
    end
    #0.5;
    for (int i = 0; i < N; i++) begin
      vectors++;
      if (bad[i]) begin
        errors++;
        $display("FAIL %s out%0d actual %b (%s) expected %s", tag, i, got_at[i],
                 "mismatch", exp[i] ? "running" : "frozen low");
      end
    end
  endtask

  task automatic send_frame(input logic [N-1:0] bits, input bit trail_idle);
    @(negedge sclk) sdat = 1'b0;
    for (int k = 0; k < N; k++) begin
      @(negedge sclk) sdat = bits[k];
    end
    if (trail_idle) begin
      @(negedge sclk) sdat = 1'b1;
    end
    model = bits;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #23 rst_n = 1'b1;
    #150;
    check_outs('1, "R1 reset");
    armed = 1'b1;

    send_frame(12'hA5C, 1'b1);
    #150;
    check_outs(model, "R3 R4 map A5C");

    check_outs(model, "R7 idle high");

    send_frame(12'h000, 1'b1);
    #150;
    check_outs(model, "R4 all frozen");

    send_frame(12'h3F0, 1'b1);
    #150;
    check_outs(model, "R8 after zero frame");

    send_frame(12'h0F0, 1'b0);
    send_frame(12'h801, 1'b1);
    #150;
    check_outs(model, "R8 back to back");

    begin
      logic [N-1:0] nb = 12'h555;
      @(negedge sclk) sdat = 1'b0;
      for (int k = 0; k < 6; k++) begin
        @(negedge sclk) sdat = nb[k];
      end
      @(posedge sclk);
      #1 run = 1'b0;
      #150;
      check_outs(model, "R5 mid frame");
      sdat = nb[6];
      run  = 1'b1;
      for (int k = 7; k < N; k++) begin
        @(negedge sclk) sdat = nb[k];
      end
      @(negedge sclk) sdat = 1'b1;
      model = nb;
    end
    #150;
    check_outs(model, "R2 R5 frame 555");

    armed = 1'b0;
    rst_n = 1'b0;
    #20;
    check_outs('1, "R1 reset held");
    rst_n = 1'b1;
    model = '1;
    #150;
    armed = 1'b1;
    check_outs(model, "R1 re-reset");

    send_frame(12'hFFE, 1'b1);
    #150;
    check_outs(model, "R3 single bit");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule